// File: doc/BRIEF.md
# Bidirectional Gray-Code Counter

A synchronous counter whose stored state is itself a reflected Gray code word, so that every counting step changes exactly one output bit. The register is a bank of D flip-flops fed by next-state logic that works directly on the Gray word. It never holds a binary count and converts nothing to binary. A direction pin chooses between stepping forward and stepping backward along the sequence, and the sequence wraps around in both directions.

A count-enable pin lets the surrounding logic advance the counter only on chosen cycles. A synchronous reset returns the state to all zeros. The width is a parameter (default 3, at least 2). Every pin is a plain control or state signal; no data stream passes through the block, so it has no valid/ready handshake.

Top module: `gray_updown_counter`

## Requirements
- R1: While `rst_i` is 1 at a rising clock edge, `gray_o` becomes 000 after that edge, whatever `cnt_en_i` and `dir_up_i` are.
- R2: With `rst_i`=0, `cnt_en_i`=1 and `dir_up_i`=1, each edge moves `gray_o` one place forward in the order 000, 001, 011, 010, 110, 111, 101, 100.
- R3: Stepping forward from 100 gives 000.
- R4: With `rst_i`=0, `cnt_en_i`=1 and `dir_up_i`=0, each edge moves `gray_o` one place backward in the same order, and stepping backward from 000 gives 100.
- R5: Every enabled step changes exactly one bit of `gray_o`.
- R6: With `rst_i`=0 and `cnt_en_i`=0, `gray_o` keeps its value and ignores `dir_up_i`.
- R7: A change of `dir_up_i` applies at the very next enabled edge. The first step in the new direction returns to the previous code, so no code is skipped or repeated.
- R8: Reset takes priority over an asserted `cnt_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; state changes on the rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| cnt_en_i | input | 1 | Count enable; 0 holds the state |
| dir_up_i | input | 1 | 1 steps forward, 0 steps backward |
| gray_o | output | W (3) | Current Gray-code state |

## Verification
On every cycle, assertions check four things: the single-bit change on each enabled step, that the state holds while enable is low, that the state clears after a reset edge, and that the decoded position moves by exactly plus or minus one modulo eight in the selected direction. Only the bench's scenarios can show the full forward and backward orders and both wraparounds. The same holds for turning the direction around mid-sequence, and for reset winning over an active enable.

// File: rtl/gray_cnt_pkg.sv
package gray_cnt_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } step_dir_e;
endpackage

// File: rtl/gray_parity.sv
module gray_parity #(
  parameter int W = 3
) (
  input  logic [W-1:0] word_i,
  output logic         odd_o
);
  logic [W-1:0] chain;

  assign chain[0] = word_i[0];
  for (genvar i = 1; i < W; i++) begin : g_chain
    assign chain[i] = chain[i-1] ^ word_i[i];
  end

  assign odd_o = chain[W-1];
endmodule

// File: rtl/gray_step.sv
module gray_step
  import gray_cnt_pkg::*;
#(
  parameter int W = 3
) (
  input  logic [W-1:0] cur_i,
  input  step_dir_e    dir_i,
  output logic [W-1:0] nxt_o
);
  logic         odd;
  logic         flip_lsb;
  logic [W-1:0] flip;

  gray_parity #(.W(W)) u_parity (
    .word_i(cur_i),
    .odd_o (odd)
  );

  // Forward: even parity toggles bit 0; odd parity toggles the bit above the
  // lowest set bit. Backward uses the opposite parity choice.
  assign flip_lsb = (dir_i == DIR_UP) ? ~odd : odd;

  always_comb begin
    logic found;
    flip  = '0;
    found = 1'b0;
    if (flip_lsb) begin
      flip[0] = 1'b1;
    end else begin
      for (int i = 0; i < W; i++) begin
        if (!found && cur_i[i]) begin
          found = 1'b1;
          flip[(i == W-1) ? i : i + 1] = 1'b1;
        end
      end
      if (!found) flip[W-1] = 1'b1;
    end
  end

  assign nxt_o = cur_i ^ flip;
endmodule

// File: rtl/gray_state_reg.sv
module gray_state_reg #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i)       q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/gray_updown_counter.sv
module gray_updown_counter
  import gray_cnt_pkg::*;
#(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         cnt_en_i,
  input  logic         dir_up_i,
  output logic [W-1:0] gray_o
);
  logic [W-1:0] state_q;
  logic [W-1:0] state_nxt;
  step_dir_e    dir;

  assign dir = step_dir_e'(dir_up_i);

  gray_step #(.W(W)) u_step (
    .cur_i(state_q),
    .dir_i(dir),
    .nxt_o(state_nxt)
  );

  gray_state_reg #(.W(W)) u_reg (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .load_i(cnt_en_i),
    .d_i   (state_nxt),
    .q_o   (state_q)
  );

  assign gray_o = state_q;

  // Assertion helpers: position of a Gray word decoded to binary.
  function automatic logic [W-1:0] pos_of(input logic [W-1:0] g);
    logic [W-1:0] b;
    b[W-1] = g[W-1];
    for (int i = W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic rst_seen_q;
  always_ff @(posedge clk_i) begin
    rst_seen_q <= rst_i;
    if (rst_seen_q) begin
      a_r1_reset_clears : assert (state_q == '0);
    end
  end

  a_r5_one_bit_moves : assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_en_i |=> ($countones(state_q ^ $past(state_q)) == 1));

  a_r6_hold_when_off : assert property (@(posedge clk_i) disable iff (rst_i)
    !cnt_en_i |=> $stable(state_q));

  a_r2_forward_pos : assert property (@(posedge clk_i) disable iff (rst_i)
    (cnt_en_i && dir_up_i) |=> (pos_of(state_q) == W'(pos_of($past(state_q)) + 1'b1)));

  a_r4_backward_pos : assert property (@(posedge clk_i) disable iff (rst_i)
    (cnt_en_i && !dir_up_i) |=> (pos_of(state_q) == W'(pos_of($past(state_q)) - 1'b1)));
endmodule

// File: tb/test_gray_updown_counter.sv
module test_gray_updown_counter;
  logic       clk = 1'b0;
  logic       rst;
  logic       en;
  logic       up;
  logic [2:0] q;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  gray_updown_counter #(.W(3)) i_gray_updown_counter (
    .clk_i   (clk),
    .rst_i   (rst),
    .cnt_en_i(en),
    .dir_up_i(up),
    .gray_o  (q)
  );

  // {rst, en, up, expected state after the edge}
  localparam int NV = 26;
  localparam logic [5:0] VECS [0:NV-1] = '{
    6'b1_0_0_000,                                         // R1
    6'b0_1_1_001, 6'b0_1_1_011, 6'b0_1_1_010, 6'b0_1_1_110, // R2
    6'b0_1_1_111, 6'b0_1_1_101, 6'b0_1_1_100,
    6'b0_1_1_000,                                         // R3 wrap
    6'b0_0_1_000,                                         // R6
    6'b0_1_0_100, 6'b0_1_0_101, 6'b0_1_0_111,             // R4
    6'b0_1_1_101,                                         // R7 turn up
    6'b0_1_0_111, 6'b0_1_0_110,                           // R7 turn down
    6'b0_0_0_110,                                         // R6
    6'b1_1_1_000,                                         // R8
    6'b0_1_0_100, 6'b0_1_0_101, 6'b0_1_0_111, 6'b0_1_0_110, // R4 wrap
    6'b0_1_0_010, 6'b0_1_0_011, 6'b0_1_0_001, 6'b0_1_0_000
  };

  task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: gray_o=%b expected %b", req, got, exp);
    end
  endtask

  task automatic step(input logic r, input logic e, input logic u);
    rst = r; en = e; up = u;
    @(negedge clk);
  endtask

  initial begin
    logic [2:0] prev;
    rst = 1'b1; en = 1'b0; up = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1", q, 3'b000);
    prev = q;

    for (int k = 0; k < NV; k++) begin
      string tag;
      step(VECS[k][5], VECS[k][4], VECS[k][3]);
      if (VECS[k][5])       tag = (VECS[k][4]) ? "R8" : "R1";
      else if (!VECS[k][4]) tag = "R6";
      else if (k == 13 || k == 14) tag = "R7";
      else                  tag = VECS[k][3] ? "R2" : "R4";
      check(tag, q, VECS[k][2:0]);
      if (!VECS[k][5] && VECS[k][4]) begin
        checks++;
        if ($countones(q ^ prev) != 1) begin
          errors++;
          $display("FAIL R5: step %b->%b flips %0d bits expected 1",
                   prev, q, $countones(q ^ prev));
        end
      end
      prev = q;
    end

    // R6: long hold with the direction pin toggling
    step(1'b0, 1'b1, 1'b1);
    check("R2", q, 3'b001);
    for (int k = 0; k < 5; k++) begin
      step(1'b0, 1'b0, k[0]);
      check("R6", q, 3'b001);
    end

    // R7: alternate direction every edge, bouncing between two codes
    step(1'b0, 1'b1, 1'b1);
    check("R7", q, 3'b011);
    step(1'b0, 1'b1, 1'b0);
    check("R7", q, 3'b001);
    step(1'b0, 1'b1, 1'b1);
    check("R7", q, 3'b011);

    // R3: run up to 100, then wrap
    for (int k = 0; k < 5; k++) step(1'b0, 1'b1, 1'b1);
    check("R2", q, 3'b100);
    step(1'b0, 1'b1, 1'b1);
    check("R3", q, 3'b000);

    // R1: reset while counting down, held over two edges
    step(1'b0, 1'b1, 1'b0);
    check("R4", q, 3'b100);
    step(1'b1, 1'b1, 1'b0);
    check("R8", q, 3'b000);
    step(1'b1, 1'b0, 1'b1);
    check("R1", q, 3'b000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule